// File: doc/BRIEF.md
# Packed Day-Time Counter with Event Flags

This block is the timekeeping core of a real-time clock. It holds elapsed time as one packed 32-bit word with seconds, minutes, hours and a 15-bit day count. Each strobe on the tick input advances the word by one second. The same tick raises sticky event flags in a status word: second, minute, hour and day rollover, a time-of-day alarm, a day-inclusive alarm and the expiry of a one-shot stopwatch countdown. A single interrupt line is driven high whenever any status bit is set whose mask bit is also set.

Software changes state through single-cycle commit strobes, each with its own data bus. There are commits for the time word, the alarm word, the stopwatch count, the interrupt mask and a write-one-to-clear of the status word. These are control writes, not a stream. Each commit is accepted in the cycle it is presented, with no ready signal and no back-pressure. A new alarm or mask value applies from the following cycle. Turning the time word into years and months is left to software.

Top module: `rtc_daytime_core`

## Requirements
- R1: The time word places seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and the day count in bits 31:17. A time commit loads the word as written, visible on `time_o` the next cycle.
- R2: On each tick, seconds advance 0..59 and then wrap to 0, carrying into minutes. Minutes advance 0..59 and carry into hours. Hours advance 0..23 and carry into the day count. The day count wraps from 32767 to 0, and that wrap sets no flag of its own.
- R3: A time commit in the same cycle as a tick takes priority: the committed word is loaded and that tick raises no time-driven event. With neither a tick nor a commit, the time word holds.
- R4: Status bit 2 (second) sets on every tick that advances the time. Bit 3 (minute) sets on the tick where seconds wrap. Bit 4 (hour) sets on the tick where minutes wrap. Bit 5 (day) sets on the tick where hours wrap.
- R5: Status bits are sticky. A clear commit clears exactly the bits written as 1, so writing 7'h7F clears all of them. An event arriving in the same cycle as its clear leaves the bit set.
- R6: Status bits set regardless of the mask. The 7-bit mask uses the same bit positions as the status word. `irq_o` is high exactly when some status bit and its mask bit are both 1.
- R7: Status bit 1 (alarm) sets on a tick whose resulting hours, minutes and seconds equal those fields of the alarm word. The alarm word uses the time-word layout, and its day field is ignored for this bit.
- R8: Status bit 6 (day alarm) sets on a tick whose resulting time matches all four fields of the alarm word, including the day.
- R9: A stopwatch commit of N>0 counts down once per tick. Status bit 0 sets on the tick that reaches 0, after which it stays at 0 with no further events until reloaded. A commit of 0 never raises bit 0. A commit in a tick cycle wins over that tick's decrement.
- R10: After reset the time word, alarm word, stopwatch count, mask and status are all 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance strobe |
| time_wr_i | input | 1 | Time word commit strobe |
| time_wdata_i | input | 32 | Time word to load |
| alarm_wr_i | input | 1 | Alarm word commit strobe |
| alarm_wdata_i | input | 32 | Alarm word, time-word layout |
| sw_wr_i | input | 1 | Stopwatch count commit strobe |
| sw_wdata_i | input | 16 | Stopwatch count to load |
| mask_wr_i | input | 1 | Interrupt mask commit strobe |
| mask_wdata_i | input | 7 | Interrupt mask value |
| clr_wr_i | input | 1 | Status clear strobe |
| clr_wdata_i | input | 7 | Status bits to clear (1 = clear) |
| time_o | output | 32 | Current packed time word |
| status_o | output | 7 | Sticky event status word |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The range assertions assume every time commit carries seconds and minutes below 60 and hours below 24. Out-of-range fields are outside the contract: the counter treats them as already at wrap. The bench therefore draws every committed field from its legal range, including the hand-picked values just below each wrap. The flag and hold assertions rely on a tick and a time commit being judged together in the same cycle, which the bench exercises both separately and in collision.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int WORD_W = 32;
  localparam int DAY_W  = WORD_W - SEC_W - MIN_W - HR_W;
  localparam int EV_N   = 7;

  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);

  // status bit positions; software decodes these
  localparam int EV_SW   = 0;
  localparam int EV_ALM  = 1;
  localparam int EV_SEC  = 2;
  localparam int EV_MIN  = 3;
  localparam int EV_HR   = 4;
  localparam int EV_DAY  = 5;
  localparam int EV_DALM = 6;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sec;
  } rtc_time_t;
endpackage

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output rtc_time_t        time_q,
  output rtc_time_t        time_nx,
  output logic             adv_o,
  output logic             ev_sec_o,
  output logic             ev_min_o,
  output logic             ev_hr_o,
  output logic             ev_day_o
);
  logic sec_wrap, min_wrap, hr_wrap;

  assign adv_o    = tick_i && !wr_i;
  assign sec_wrap = time_q.sec >= SEC_LAST;
  assign min_wrap = time_q.mn  >= MIN_LAST;
  assign hr_wrap  = time_q.hr  >= HR_LAST;

  assign ev_sec_o = adv_o;
  assign ev_min_o = adv_o && sec_wrap;
  assign ev_hr_o  = ev_min_o && min_wrap;
  assign ev_day_o = ev_hr_o && hr_wrap;

  always_comb begin
    time_nx = time_q;
    if (wr_i) begin
      time_nx = rtc_time_t'(wdata_i);
    end else if (adv_o) begin
      time_nx.sec = sec_wrap ? '0 : time_q.sec + SEC_W'(1);
      if (ev_min_o) time_nx.mn  = min_wrap ? '0 : time_q.mn + MIN_W'(1);
      if (ev_hr_o)  time_nx.hr  = hr_wrap  ? '0 : time_q.hr + HR_W'(1);
      if (ev_day_o) time_nx.day = time_q.day + DAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_nx;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              adv_i,
  input  rtc_time_t         time_nx,
  output logic              hit_tod_o,
  output logic              hit_day_o
);
  rtc_time_t alarm_q;
  logic      tod_eq;

  always_ff @(posedge clk) begin
    if (!rst_n)    alarm_q <= '0;
    else if (wr_i) alarm_q <= rtc_time_t'(wdata_i);
  end

  assign tod_eq    = (time_nx.hr == alarm_q.hr) && (time_nx.mn == alarm_q.mn) &&
                     (time_nx.sec == alarm_q.sec);
  assign hit_tod_o = adv_i && tod_eq;
  assign hit_day_o = hit_tod_o && (time_nx.day == alarm_q.day);
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run      = tick_i && !wr_i && (cnt_q != '0);
  assign expire_o = run && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (run)  cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_q,
  output logic         irq_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= set_i[i] | (status_q[i] & ~(clr_wr_i & clr_i[i]));
    end
  end

  assign irq_o = |(status_q & mask_q);
endmodule

// File: rtl/rtc_daytime_core.sv
module rtc_daytime_core
  import rtc_pkg::*;
#(
  parameter int SW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              time_wr_i,
  input  logic [WORD_W-1:0] time_wdata_i,
  input  logic              alarm_wr_i,
  input  logic [WORD_W-1:0] alarm_wdata_i,
  input  logic              sw_wr_i,
  input  logic [SW_W-1:0]   sw_wdata_i,
  input  logic              mask_wr_i,
  input  logic [EV_N-1:0]   mask_wdata_i,
  input  logic              clr_wr_i,
  input  logic [EV_N-1:0]   clr_wdata_i,
  output logic [WORD_W-1:0] time_o,
  output logic [EV_N-1:0]   status_o,
  output logic              irq_o
);
  rtc_time_t       time_q, time_nx;
  logic            adv, ev_sec, ev_min, ev_hr, ev_day;
  logic            hit_tod, hit_day, sw_exp;
  logic [EV_N-1:0] ev_set;

  rtc_time_adv u_adv (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(time_wr_i),
    .wdata_i(time_wdata_i), .time_q(time_q), .time_nx(time_nx), .adv_o(adv),
    .ev_sec_o(ev_sec), .ev_min_o(ev_min), .ev_hr_o(ev_hr), .ev_day_o(ev_day)
  );

  rtc_alarm_match u_alm (
    .clk(clk), .rst_n(rst_n), .wr_i(alarm_wr_i), .wdata_i(alarm_wdata_i),
    .adv_i(adv), .time_nx(time_nx), .hit_tod_o(hit_tod), .hit_day_o(hit_day)
  );

  rtc_stopwatch #(.CNT_W(SW_W)) u_sw (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(sw_wr_i),
    .wdata_i(sw_wdata_i), .expire_o(sw_exp)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_SW]   = sw_exp;
    ev_set[EV_ALM]  = hit_tod;
    ev_set[EV_SEC]  = ev_sec;
    ev_set[EV_MIN]  = ev_min;
    ev_set[EV_HR]   = ev_hr;
    ev_set[EV_DAY]  = ev_day;
    ev_set[EV_DALM] = hit_day;
  end

  rtc_evt_status #(.N(EV_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_wr_i(clr_wr_i),
    .clr_i(clr_wdata_i), .mask_wr_i(mask_wr_i), .mask_i(mask_wdata_i),
    .status_q(status_o), .irq_o(irq_o)
  );

  assign time_o = time_q;
endmodule

// File: rtl/rtc_daytime_chk.sv
module rtc_daytime_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              time_wr_i,
  input logic [WORD_W-1:0] time_wdata_i,
  input logic              clr_wr_i,
  input logic [EV_N-1:0]   clr_wdata_i,
  input logic [WORD_W-1:0] time_o,
  input logic [EV_N-1:0]   status_o,
  input logic              irq_o
);
  p_commit_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_i |=> time_o == $past(time_wdata_i));

  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (time_o[5:0] <= 6'd59) && (time_o[11:6] <= 6'd59) && (time_o[16:12] <= 5'd23));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !time_wr_i) |=> $stable(time_o));

  p_second_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !time_wr_i) |=> status_o[2]);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  p_clear_minute_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && clr_wdata_i[3] && !tick_i) |=> !status_o[3]);

  p_irq_needs_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o != '0));
endmodule

bind rtc_daytime_core rtc_daytime_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .time_wr_i(time_wr_i),
  .time_wdata_i(time_wdata_i), .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i),
  .time_o(time_o), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/sim_rtc_daytime_core.sv
`timescale 1ns/1ps
module sim_rtc_daytime_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, time_wr = 1'b0, alarm_wr = 1'b0, sw_wr = 1'b0;
  logic        mask_wr = 1'b0, clr_wr = 1'b0;
  logic [31:0] time_wd = '0, alarm_wd = '0;
  logic [15:0] sw_wd = '0;
  logic [6:0]  mask_wd = '0, clr_wd = '0;
  logic [31:0] time_o;
  logic [6:0]  status_o;
  logic        irq_o;

  int total = 0, bad = 0, cycles = 0;
  string phase = "R10 reset";

  // reference model state
  int m_sec = 0, m_min = 0, m_hr = 0, m_day = 0, m_sw = 0;
  int a_sec = 0, a_min = 0, a_hr = 0, a_day = 0;
  logic [6:0] m_stat = '0, m_mask = '0;

  always #4 clk = ~clk;

  rtc_daytime_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .time_wr_i(time_wr),
    .time_wdata_i(time_wd), .alarm_wr_i(alarm_wr), .alarm_wdata_i(alarm_wd),
    .sw_wr_i(sw_wr), .sw_wdata_i(sw_wd), .mask_wr_i(mask_wr),
    .mask_wdata_i(mask_wd), .clr_wr_i(clr_wr), .clr_wdata_i(clr_wd),
    .time_o(time_o), .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] mk(int d, int h, int m, int s);
    logic [31:0] w;
    w = {d[14:0], h[4:0], m[5:0], s[5:0]};
    return w;
  endfunction

  always @(posedge clk) begin
    logic [6:0] set;
    logic [6:0] clr;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_sw = 0;
      a_sec = 0; a_min = 0; a_hr = 0; a_day = 0; m_stat = '0; m_mask = '0;
    end else begin
      set = '0;
      clr = clr_wr ? clr_wd : '0;
      if (time_wr) begin
        m_sec = int'(time_wd[5:0]); m_min = int'(time_wd[11:6]);
        m_hr = int'(time_wd[16:12]); m_day = int'(time_wd[31:17]);
      end else if (tick) begin
        set[2] = 1'b1;
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++; set[3] = 1'b1;
          if (m_min == 60) begin
            m_min = 0; m_hr++; set[4] = 1'b1;
            if (m_hr == 24) begin
              m_hr = 0; set[5] = 1'b1; m_day = (m_day + 1) % 32768;
            end
          end
        end
        if (m_hr == a_hr && m_min == a_min && m_sec == a_sec) begin
          set[1] = 1'b1;
          if (m_day == a_day) set[6] = 1'b1;
        end
      end
      if (sw_wr) m_sw = int'(sw_wd);
      else if (tick && m_sw != 0) begin
        m_sw--;
        if (m_sw == 0) set[0] = 1'b1;
      end
      if (alarm_wr) begin
        a_sec = int'(alarm_wd[5:0]); a_min = int'(alarm_wd[11:6]);
        a_hr = int'(alarm_wd[16:12]); a_day = int'(alarm_wd[31:17]);
      end
      if (mask_wr) m_mask = mask_wd;
      m_stat = (m_stat & ~clr) | set;
    end
  end

  // compare with the model on every clock once out of reset
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (time_o !== mk(m_day, m_hr, m_min, m_sec) || status_o !== m_stat ||
          irq_o !== |(m_stat & m_mask)) begin
        bad++;
        $display("FAIL %s model: time=%h/%h status=%b/%b irq=%b/%b", phase,
                 time_o, mk(m_day, m_hr, m_min, m_sec), status_o, m_stat,
                 irq_o, |(m_stat & m_mask));
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 0; time_wr = 0; alarm_wr = 0; sw_wr = 0; mask_wr = 0; clr_wr = 0;
    end
  endtask

  task automatic set_time(logic [31:0] w);
    time_wr = 1; time_wd = w; cyc();
  endtask

  task automatic clr_all();
    clr_wr = 1; clr_wd = 7'h7F; cyc();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1;
    cyc();
    phase = "R10 reset";
    chk("R10 time", time_o, 32'h0);
    chk("R10 status", {25'd0, status_o}, 32'h0);
    chk("R10 irq", {31'd0, irq_o}, 32'h0);

    phase = "R1 commit";
    set_time(mk(3, 4, 5, 6));
    chk("R1 layout", time_o, 32'h00064146);
    phase = "R3 hold";
    cyc(3);
    chk("R3 hold", time_o, 32'h00064146);

    phase = "R4 minute";
    set_time(mk(0, 0, 0, 58));
    ticks(1);
    chk("R4 second flag", {25'd0, status_o}, 32'h04);
    ticks(1);
    chk("R2 minute carry", time_o, mk(0, 0, 1, 0));
    chk("R4 minute flag", {31'd0, status_o[3]}, 32'h1);

    phase = "R2 day wrap";
    alarm_wr = 1; alarm_wd = mk(7, 12, 0, 0); cyc();
    clr_all();
    set_time(mk(32767, 23, 59, 59));
    ticks(1);
    chk("R2 day wrap time", time_o, 32'h0);
    chk("R2 R4 wrap flags", {25'd0, status_o}, 32'h3C);

    phase = "R6 mask";
    chk("R6 irq masked", {31'd0, irq_o}, 32'h0);
    mask_wr = 1; mask_wd = 7'h04; cyc();
    chk("R6 irq raised", {31'd0, irq_o}, 32'h1);
    phase = "R5 clear";
    clr_wr = 1; clr_wd = 7'h04; cyc();
    chk("R5 w1c one bit", {25'd0, status_o}, 32'h38);
    chk("R6 irq dropped", {31'd0, irq_o}, 32'h0);
    clr_all();
    chk("R5 clear all", {25'd0, status_o}, 32'h0);
    tick = 1; clr_wr = 1; clr_wd = 7'h04; cyc();
    chk("R5 set beats clear", {31'd0, status_o[2]}, 32'h1);

    phase = "R3 collision";
    set_time(mk(1, 1, 1, 1));
    clr_all();
    tick = 1; time_wr = 1; time_wd = mk(2, 2, 2, 2); cyc();
    chk("R3 commit wins", time_o, mk(2, 2, 2, 2));
    chk("R3 no event", {25'd0, status_o}, 32'h0);

    phase = "R7 alarm";
    alarm_wr = 1; alarm_wd = mk(9, 1, 0, 5); cyc();
    set_time(mk(2, 1, 0, 3));
    clr_all();
    ticks(1);
    chk("R7 not yet", {31'd0, status_o[1]}, 32'h0);
    ticks(1);
    chk("R7 tod alarm", {31'd0, status_o[1]}, 32'h1);
    chk("R8 day differs", {31'd0, status_o[6]}, 32'h0);
    phase = "R8 day alarm";
    set_time(mk(9, 1, 0, 3));
    clr_all();
    ticks(2);
    chk("R8 day alarm", {30'd0, status_o[6], status_o[1]}, 32'h3);

    phase = "R9 stopwatch";
    sw_wr = 1; sw_wd = 16'd3; cyc();
    clr_all();
    ticks(2);
    chk("R9 counting", {31'd0, status_o[0]}, 32'h0);
    ticks(1);
    chk("R9 expired", {31'd0, status_o[0]}, 32'h1);
    clr_all();
    ticks(5);
    chk("R9 stays expired", {31'd0, status_o[0]}, 32'h0);
    sw_wr = 1; sw_wd = 16'd0; cyc();
    ticks(4);
    chk("R9 zero load", {31'd0, status_o[0]}, 32'h0);
    tick = 1; sw_wr = 1; sw_wd = 16'd1; cyc();
    chk("R9 load beats tick", {31'd0, status_o[0]}, 32'h0);
    ticks(1);
    chk("R9 load of one", {31'd0, status_o[0]}, 32'h1);

    phase = "R2 R4 R7 R9 mixed";
    mask_wr = 1; mask_wd = 7'h53; cyc();
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      tick = (r < 80);
      if (r >= 97) begin
        time_wr = 1;
        time_wd = mk(int'($urandom % 32768), (r == 99) ? 23 : int'($urandom % 24),
                     int'($urandom % 2) ? 59 : int'($urandom % 60),
                     55 + int'($urandom % 5));
      end else if (r == 96) begin
        alarm_wr = 1;
        alarm_wd = mk(int'($urandom % 4), int'($urandom % 24), int'($urandom % 60),
                      int'($urandom % 60));
      end else if (r == 95) begin
        sw_wr = 1; sw_wd = 16'($urandom % 6);
      end else if (r == 94) begin
        clr_wr = 1; clr_wd = 7'($urandom);
      end else if (r == 93) begin
        mask_wr = 1; mask_wd = 7'($urandom);
      end
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule